// File: doc/BRIEF.md
# Byte-Sliced Multi-Width Accumulator Datapath

This block is the execute stage of a one-operand accumulator machine whose only arithmetic unit is eight bits wide. Every arithmetic, logic, load and store instruction pairs the 32-bit accumulator with one operand, and the accumulator is the only result destination. A per-instruction width code picks 8, 16 or 32 bits. The block then walks the accumulator one byte per clock, least significant byte first, and passes the carry or borrow from one byte to the next.

The operand comes from one of four places: one of four 32-bit general registers, memory addressed by one of four 16-bit pointers, a 6-bit offset inside a selectable memory block, or a 2-bit signed constant. Pointers can be stepped up or down, loaded from the accumulator and read back into it. Memory sits outside the block on a byte-wide port with an asynchronous read. Instruction fetch and decode are upstream, and they hand over one already decoded instruction with a start strobe.

Top module: `slice_acc_dp`

## Requirements
- R1: During reset and right after it, the accumulator, all general registers and all pointers are zero, and `busy_o` and `done_o` are low.
- R2: `start_i` is taken only while `busy_o` is low, and a start seen while busy has no effect. Width code 0 (8 bits) takes 1 busy cycle, code 1 (16 bits) takes 2, and codes 2 and 3 (32 bits) take 4. Pointer opcodes and unused opcodes 12 to 15 take 1 busy cycle and change nothing else. `done_o` is high for exactly one cycle, the cycle after the last busy cycle, and the accumulator never changes while the block is idle.
- R3: Opcode 0 adds the operand to the accumulator. The carry of each byte goes into the next byte, and the carry out of the top selected byte is dropped.
- R4: Opcode 1 subtracts the operand in two's complement. The borrow chains across bytes.
- R5: Opcodes 2, 3 and 4 perform bitwise AND, OR and XOR.
- R6: Opcode 5 shifts the selected width of the accumulator left by one. A zero enters at bit 0, and the top bit of the selected width is lost. The operand is ignored.
- R7: For opcodes 0 to 6 with 8- or 16-bit width, the accumulator bits above the width keep their value.
- R8: Source code 0 selects general register `sel_i`. Code 1 selects memory at pointer `sel_i` plus the byte index. Code 2 selects memory at {block, offset} plus the byte index, where the block code gives address bits 15:6 and the offset gives bits 5:0. Code 3 selects the 2-bit constant, sign-extended to the width.
- R9: Opcode 6 loads the operand into the accumulator. Opcode 7 stores the accumulator: into a register it writes only the bytes within the width, into memory it writes one byte per cycle at ascending addresses, and with source code 3 it writes nothing. A store leaves the accumulator unchanged.
- R10: Opcodes 8 and 9 add or subtract one from pointer `sel_i`, wrapping modulo 2^16. Opcode 10 copies accumulator bits 15:0 into the pointer. Opcode 11 loads the pointer into the accumulator, zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start_i | input | 1 | Begin the instruction presented on the inputs below |
| op_i | input | 4 | Opcode |
| width_i | input | 2 | Width code: 0 = 8, 1 = 16, 2 or 3 = 32 bits |
| src_i | input | 2 | Operand source code |
| sel_i | input | 2 | Register or pointer index |
| dir_i | input | 6 | Offset inside the block |
| imm_i | input | 2 | Signed constant |
| block_i | input | 10 | Working block, address bits 15:6 |
| mem_addr_o | output | 16 | Memory byte address |
| mem_wdata_o | output | 8 | Memory write byte |
| mem_we_o | output | 1 | Memory write strobe |
| mem_rdata_i | input | 8 | Memory read byte, combinational from the address |
| busy_o | output | 1 | Instruction in progress |
| done_o | output | 1 | One-cycle pulse when an instruction completes |
| acc_o | output | 32 | Accumulator |

## Verification
The add, subtract and shift patterns are chosen so that a carry or borrow must cross every byte boundary, such as -1 plus 1 and 0 minus 1. These expose a broken chain or a wrong first carry. The same opcodes run at 8 and 16 bits on values whose upper bytes are nonzero, so a slice count that is too long, or a top carry that leaks upward, changes bits that must stay put. Operands are drawn from registers, pointers, block-relative offsets and the negative constants. A half-width store followed by a full-width load tells byte lanes and addresses apart. Pointer wrap below zero and a start strobe while busy cover the edge cases.

// File: rtl/sacc_pkg.sv
package sacc_pkg;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_AND  = 4'd2,
        OP_OR   = 4'd3,
        OP_XOR  = 4'd4,
        OP_SHL  = 4'd5,
        OP_LDA  = 4'd6,
        OP_STA  = 4'd7,
        OP_PINC = 4'd8,
        OP_PDEC = 4'd9,
        OP_PLD  = 4'd10,
        OP_PGET = 4'd11,
        OP_RSV0 = 4'd12,
        OP_RSV1 = 4'd13,
        OP_RSV2 = 4'd14,
        OP_RSV3 = 4'd15
    } op_e;

    typedef enum logic [1:0] {
        SRC_REG = 2'd0,
        SRC_PTR = 2'd1,
        SRC_DIR = 2'd2,
        SRC_IMM = 2'd3
    } src_e;

    typedef enum logic [1:0] {
        WID_8   = 2'd0,
        WID_16  = 2'd1,
        WID_32  = 2'd2,
        WID_32X = 2'd3
    } wid_e;

endpackage

// File: rtl/sacc_byte_alu.sv
module sacc_byte_alu
    import sacc_pkg::*;
(
    input  op_e        op,
    input  logic [7:0] a,
    input  logic [7:0] b,
    input  logic       cin,
    output logic [7:0] y,
    output logic       cout
);
    logic [7:0] b_eff;
    logic [8:0] sum;

    always_comb begin
        b_eff = (op == OP_SUB) ? ~b : b;
        sum   = {1'b0, a} + {1'b0, b_eff} + {8'd0, cin};
        y     = a;
        cout  = 1'b0;
        case (op)
            OP_ADD, OP_SUB: begin
                y    = sum[7:0];
                cout = sum[8];
            end
            OP_AND: y = a & b;
            OP_OR:  y = a | b;
            OP_XOR: y = a ^ b;
            OP_SHL: begin
                y    = {a[6:0], cin};
                cout = a[7];
            end
            OP_LDA: y = b;
            default: y = a;
        endcase
    end
endmodule

// File: rtl/sacc_regfile.sv
module sacc_regfile #(
    parameter int N = 4,
    parameter int W = 32,
    localparam int IW = $clog2(N),
    localparam int NB = W / 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic [IW-1:0]       widx,
    input  logic [NB-1:0]       be,
    input  logic [W-1:0]        wdata,
    output logic [N-1:0][W-1:0] rd
);
    logic [N-1:0][W-1:0] regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        for (int b = 0; b < NB; b++) begin
            if (we && be[b]) begin
                regs_d[widx][b*8 +: 8] = wdata[b*8 +: 8];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign rd = regs_q;
endmodule

// File: rtl/slice_acc_dp.sv
module slice_acc_dp
    import sacc_pkg::*;
#(
    parameter int ACC_W  = 32,
    parameter int ADDR_W = 16,
    parameter int NREG   = 4,
    parameter int DIR_W  = 6,
    parameter int IMM_W  = 2,
    localparam int NB    = ACC_W / 8,
    localparam int IDX_W = (NB > 1) ? $clog2(NB) : 1,
    localparam int SEL_W = $clog2(NREG),
    localparam int BLK_W = ADDR_W - DIR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [3:0]        op_i,
    input  logic [1:0]        width_i,
    input  logic [1:0]        src_i,
    input  logic [SEL_W-1:0]  sel_i,
    input  logic [DIR_W-1:0]  dir_i,
    input  logic [IMM_W-1:0]  imm_i,
    input  logic [BLK_W-1:0]  block_i,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [7:0]        mem_wdata_o,
    output logic              mem_we_o,
    input  logic [7:0]        mem_rdata_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [ACC_W-1:0]  acc_o
);
    typedef struct packed {
        logic             busy;
        logic             done;
        op_e              op;
        src_e             src;
        logic [SEL_W-1:0] sel;
        logic [DIR_W-1:0] dir;
        logic [IMM_W-1:0] imm;
        logic [BLK_W-1:0] blk;
        logic [IDX_W-1:0] idx;
        logic [IDX_W-1:0] last;
        logic             carry;
        logic [ACC_W-1:0] acc;
    } st_t;

    st_t st_d, st_q;

    logic [NREG-1:0][ACC_W-1:0]  gpr_rd;
    logic [NREG-1:0][ADDR_W-1:0] ptr_rd;
    logic                        gpr_we, ptr_we;
    logic [NB-1:0]               gpr_be;
    logic [ADDR_W-1:0]           ptr_wdata;
    logic [7:0]                  opnd, acc_byte, alu_y, imm_byte;
    logic                        alu_cin, alu_cout;

    sacc_regfile #(.N(NREG), .W(ACC_W)) u_gpr (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (gpr_we),
        .widx (st_q.sel),
        .be   (gpr_be),
        .wdata(st_q.acc),
        .rd   (gpr_rd)
    );

    sacc_regfile #(.N(NREG), .W(ADDR_W)) u_ptr (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (ptr_we),
        .widx (st_q.sel),
        .be   ({(ADDR_W/8){1'b1}}),
        .wdata(ptr_wdata),
        .rd   (ptr_rd)
    );

    sacc_byte_alu u_alu (
        .op  (st_q.op),
        .a   (acc_byte),
        .b   (opnd),
        .cin (alu_cin),
        .y   (alu_y),
        .cout(alu_cout)
    );

    // Operand byte selection and memory addressing for the current slice
    always_comb begin
        acc_byte = st_q.acc[st_q.idx*8 +: 8];
        imm_byte = (st_q.idx == '0) ?
                   {{(8-IMM_W){st_q.imm[IMM_W-1]}}, st_q.imm} :
                   {8{st_q.imm[IMM_W-1]}};
        alu_cin  = (st_q.idx == '0) ? (st_q.op == OP_SUB) : st_q.carry;
        case (st_q.src)
            SRC_PTR: mem_addr_o = ptr_rd[st_q.sel] + ADDR_W'(st_q.idx);
            SRC_DIR: mem_addr_o = {st_q.blk, st_q.dir} + ADDR_W'(st_q.idx);
            default: mem_addr_o = '0;
        endcase
        case (st_q.src)
            SRC_REG: opnd = gpr_rd[st_q.sel][st_q.idx*8 +: 8];
            SRC_IMM: opnd = imm_byte;
            default: opnd = mem_rdata_i;
        endcase
    end

    // Sequencer: next state and register-file write controls
    always_comb begin
        st_d        = st_q;
        st_d.done   = 1'b0;
        gpr_we      = 1'b0;
        gpr_be      = NB'(1) << st_q.idx;
        ptr_we      = 1'b0;
        ptr_wdata   = st_q.acc[ADDR_W-1:0];
        mem_we_o    = 1'b0;
        mem_wdata_o = acc_byte;

        if (st_q.busy) begin
            case (st_q.op)
                OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR, OP_SHL, OP_LDA: begin
                    st_d.acc[st_q.idx*8 +: 8] = alu_y;
                    st_d.carry                = alu_cout;
                end
                OP_STA: begin
                    if (st_q.src == SRC_REG) gpr_we = 1'b1;
                    else if (st_q.src != SRC_IMM) mem_we_o = 1'b1;
                end
                OP_PINC: begin
                    ptr_we    = 1'b1;
                    ptr_wdata = ptr_rd[st_q.sel] + ADDR_W'(1);
                end
                OP_PDEC: begin
                    ptr_we    = 1'b1;
                    ptr_wdata = ptr_rd[st_q.sel] - ADDR_W'(1);
                end
                OP_PLD: ptr_we = 1'b1;
                OP_PGET: st_d.acc = ACC_W'(ptr_rd[st_q.sel]);
                default: ;
            endcase

            if (st_q.op > OP_STA || st_q.idx == st_q.last) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end else begin
                st_d.idx = st_q.idx + IDX_W'(1);
            end
        end else if (start_i) begin
            st_d.busy  = 1'b1;
            st_d.op    = op_e'(op_i);
            st_d.src   = src_e'(src_i);
            st_d.sel   = sel_i;
            st_d.dir   = dir_i;
            st_d.imm   = imm_i;
            st_d.blk   = block_i;
            st_d.idx   = '0;
            st_d.carry = 1'b0;
            case (wid_e'(width_i))
                WID_8:   st_d.last = '0;
                WID_16:  st_d.last = IDX_W'(1);
                default: st_d.last = IDX_W'(NB - 1);
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy_o = st_q.busy;
    assign done_o = st_q.done;
    assign acc_o  = st_q.acc;

    // Views of latched state for the bound checker
    logic [3:0]       chk_op;
    logic [IDX_W-1:0] chk_last;
    assign chk_op   = st_q.op;
    assign chk_last = st_q.last;
endmodule

// File: rtl/sacc_checker.sv
module sacc_checker #(
    parameter int ACC_W = 32,
    localparam int IDX_W = (ACC_W / 8 > 1) ? $clog2(ACC_W / 8) : 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             done,
    input logic             mem_we,
    input logic [ACC_W-1:0] acc,
    input logic [3:0]       cur_op,
    input logic [IDX_W-1:0] cur_last
);
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);  // R2

    AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(busy));  // R2

    AST_IDLE_ACC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(acc));  // R2

    AST_BYTE_UPPER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cur_op <= 4'd6 && cur_last == '0) |=> $stable(acc[ACC_W-1:8]));  // R7

    AST_HALF_UPPER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cur_op <= 4'd6 && cur_last == IDX_W'(1)) |=> $stable(acc[ACC_W-1:16]));  // R7

    AST_STORE_ACC_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cur_op == 4'd7) |=> $stable(acc));  // R9

    AST_WRITE_ONLY_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (busy && cur_op == 4'd7));  // R9
endmodule

bind slice_acc_dp sacc_checker #(.ACC_W(ACC_W)) u_sacc_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy    (busy_o),
    .done    (done_o),
    .mem_we  (mem_we_o),
    .acc     (acc_o),
    .cur_op  (chk_op),
    .cur_last(chk_last)
);

// File: tb/slice_acc_dp_bench.sv
module slice_acc_dp_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [3:0]  op_i = '0;
    logic [1:0]  width_i = '0, src_i = '0, sel_i = '0, imm_i = '0;
    logic [5:0]  dir_i = '0;
    logic [9:0]  block_i = '0;
    logic [15:0] mem_addr_o;
    logic [7:0]  mem_wdata_o, mem_rdata_i;
    logic        mem_we_o, busy_o, done_o;
    logic [31:0] acc_o;

    int applied = 0;
    int errors  = 0;
    logic [7:0] mem [0:1023];

    always #2.5 clk = ~clk;

    slice_acc_dp u_slice_acc_dp (.*);

    assign mem_rdata_i = mem[mem_addr_o[9:0]];
    always @(posedge clk) if (mem_we_o) mem[mem_addr_o[9:0]] <= mem_wdata_o;

    // {op, width, src, sel, dir, imm, block, expected accumulator}
    localparam int NV = 38;
    localparam logic [59:0] VEC [0:NV-1] = '{
        {4'd6, 2'd2, 2'd2, 2'd0, 6'h10, 2'd0, 10'd0, 32'h12345678},
        {4'd7, 2'd2, 2'd0, 2'd0, 6'h00, 2'd0, 10'd0, 32'h12345678},
        {4'd6, 2'd2, 2'd3, 2'd0, 6'h00, 2'd3, 10'd0, 32'hFFFFFFFF},
        {4'd0, 2'd2, 2'd3, 2'd0, 6'h00, 2'd1, 10'd0, 32'h00000000},
        {4'd6, 2'd2, 2'd2, 2'd0, 6'h14, 2'd0, 10'd0, 32'h800000FF},
        {4'd0, 2'd1, 2'd3, 2'd0, 6'h00, 2'd1, 10'd0, 32'h80000100},
        {4'd0, 2'd0, 2'd0, 2'd0, 6'h00, 2'd0, 10'd0, 32'h80000178},
        {4'd1, 2'd2, 2'd0, 2'd0, 6'h00, 2'd0, 10'd0, 32'h6DCBAB00},
        {4'd1, 2'd0, 2'd3, 2'd0, 6'h00, 2'd1, 10'd0, 32'h6DCBABFF},
        {4'd2, 2'd2, 2'd0, 2'd0, 6'h00, 2'd0, 10'd0, 32'h00000278},
        {4'd3, 2'd1, 2'd3, 2'd0, 6'h00, 2'd2, 10'd0, 32'h0000FFFE},
        {4'd4, 2'd2, 2'd0, 2'd0, 6'h00, 2'd0, 10'd0, 32'h1234A986},
        {4'd5, 2'd0, 2'd3, 2'd0, 6'h00, 2'd3, 10'd0, 32'h1234A90C},
        {4'd5, 2'd2, 2'd3, 2'd0, 6'h00, 2'd3, 10'd0, 32'h24695218},
        {4'd5, 2'd1, 2'd3, 2'd0, 6'h00, 2'd3, 10'd0, 32'h2469A430},
        {4'd7, 2'd1, 2'd0, 2'd1, 6'h00, 2'd0, 10'd0, 32'h2469A430},
        {4'd6, 2'd2, 2'd0, 2'd1, 6'h00, 2'd0, 10'd0, 32'h0000A430},
        {4'd6, 2'd3, 2'd2, 2'd0, 6'h10, 2'd0, 10'd0, 32'h12345678},
        {4'd6, 2'd2, 2'd2, 2'd0, 6'h18, 2'd0, 10'd0, 32'h00000100},
        {4'd10,2'd2, 2'd0, 2'd2, 6'h00, 2'd0, 10'd0, 32'h00000100},
        {4'd8, 2'd2, 2'd0, 2'd2, 6'h00, 2'd0, 10'd0, 32'h00000100},
        {4'd11,2'd2, 2'd0, 2'd2, 6'h00, 2'd0, 10'd0, 32'h00000101},
        {4'd6, 2'd2, 2'd1, 2'd2, 6'h00, 2'd0, 10'd0, 32'hDDCCBBAA},
        {4'd9, 2'd2, 2'd0, 2'd2, 6'h00, 2'd0, 10'd0, 32'hDDCCBBAA},
        {4'd11,2'd2, 2'd0, 2'd2, 6'h00, 2'd0, 10'd0, 32'h00000100},
        {4'd9, 2'd2, 2'd0, 2'd3, 6'h00, 2'd0, 10'd0, 32'h00000100},
        {4'd11,2'd2, 2'd0, 2'd3, 6'h00, 2'd0, 10'd0, 32'h0000FFFF},
        {4'd6, 2'd2, 2'd2, 2'd0, 6'h10, 2'd0, 10'd0, 32'h12345678},
        {4'd7, 2'd1, 2'd1, 2'd2, 6'h00, 2'd0, 10'd0, 32'h12345678},
        {4'd6, 2'd2, 2'd1, 2'd2, 6'h00, 2'd0, 10'd0, 32'hCCBB5678},
        {4'd7, 2'd2, 2'd3, 2'd0, 6'h00, 2'd0, 10'd0, 32'hCCBB5678},
        {4'd6, 2'd2, 2'd1, 2'd2, 6'h00, 2'd0, 10'd0, 32'hCCBB5678},
        {4'd6, 2'd2, 2'd2, 2'd0, 6'h01, 2'd0, 10'd4, 32'hDDCCBB56},
        {4'd1, 2'd2, 2'd3, 2'd0, 6'h00, 2'd1, 10'd0, 32'hDDCCBB55},
        {4'd6, 2'd2, 2'd3, 2'd0, 6'h00, 2'd0, 10'd0, 32'h00000000},
        {4'd1, 2'd2, 2'd3, 2'd0, 6'h00, 2'd1, 10'd0, 32'hFFFFFFFF},
        {4'd1, 2'd1, 2'd3, 2'd0, 6'h00, 2'd1, 10'd0, 32'hFFFFFFFE},
        {4'd12,2'd2, 2'd3, 2'd0, 6'h00, 2'd1, 10'd0, 32'hFFFFFFFE}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        applied++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic string tag_of(input logic [3:0] op, input logic [1:0] w);
        case (op)
            4'd0: return (w < 2) ? "R3 R7" : "R3";
            4'd1: return (w < 2) ? "R4 R7" : "R4";
            4'd2, 4'd3, 4'd4: return (w < 2) ? "R5 R7" : "R5";
            4'd5: return (w < 2) ? "R6 R7" : "R6";
            4'd6: return "R8 R9";
            4'd7: return "R9";
            4'd8, 4'd9, 4'd10, 4'd11: return "R10";
            default: return "R2";
        endcase
    endfunction

    // Drives one instruction and returns the number of busy cycles seen
    task automatic run_instr(input logic [3:0] op, input logic [1:0] w, input logic [1:0] src,
                             input logic [1:0] sel, input logic [5:0] dir, input logic [1:0] imm,
                             input logic [9:0] blk, output int cycles);
        @(negedge clk);
        op_i = op; width_i = w; src_i = src; sel_i = sel; dir_i = dir; imm_i = imm; block_i = blk;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        cycles = 0;
        for (int guard = 0; guard < 50 && !done_o; guard++) begin
            if (busy_o) cycles++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", applied, errors);
        $finish;
    end

    initial begin
        int cyc, exp_cyc;
        logic [31:0] saved;
        for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
        {mem[16], mem[17], mem[18], mem[19]} = {8'h78, 8'h56, 8'h34, 8'h12};
        {mem[20], mem[21], mem[22], mem[23]} = {8'hFF, 8'h00, 8'h00, 8'h80};
        {mem[24], mem[25], mem[26], mem[27]} = {8'h00, 8'h01, 8'h00, 8'h00};
        {mem[257], mem[258], mem[259], mem[260]} = {8'hAA, 8'hBB, 8'hCC, 8'hDD};

        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 acc", acc_o, 32'h0);
        check("R1 busy/done", {30'd0, busy_o, done_o}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 acc after release", acc_o, 32'h0);

        for (int v = 0; v < NV; v++) begin
            logic [59:0] e;
            e = VEC[v];
            run_instr(e[59:56], e[55:54], e[53:52], e[51:50], e[49:44], e[43:42], e[41:32], cyc);
            check(tag_of(e[59:56], e[55:54]), acc_o, e[31:0]);
            // R2: slice count
            if (e[59:56] > 4'd7) exp_cyc = 1;
            else if (e[55:54] == 2'd0) exp_cyc = 1;
            else if (e[55:54] == 2'd1) exp_cyc = 2;
            else exp_cyc = 4;
            check("R2 busy cycles", cyc, exp_cyc);
            @(negedge clk);
            check("R2 done one cycle", {31'd0, done_o}, 32'd0);
        end

        // R9: half-width store to memory wrote bytes 0x100, 0x101 only
        check("R9 mem bytes", {mem[259], mem[258], mem[257], mem[256]}, 32'hCCBB5678);

        // R2: start while busy is ignored
        @(negedge clk);
        op_i = 4'd0; width_i = 2'd2; src_i = 2'd3; imm_i = 2'd1; start_i = 1'b1;
        @(negedge clk);
        op_i = 4'd6; imm_i = 2'd0;
        @(negedge clk);
        start_i = 1'b0;
        for (int g = 0; g < 20 && !done_o; g++) @(negedge clk);
        check("R2 ignored start result", acc_o, 32'hFFFFFFFF);
        repeat (3) @(negedge clk);
        check("R2 no extra run", {30'd0, busy_o, done_o}, 32'h0);
        saved = acc_o;
        check("R2 idle hold", acc_o, saved);

        $display("== %0d vectors applied, %0d miscompares ==", applied, errors);
        $finish;
    end
endmodule